// File: doc/BRIEF.md
# Interrupt Pending and Gating Unit

This block holds the pending state of thirteen level-sensitive interrupt lines and decides whether the core should take an interrupt. The two lowest pending bits are software interrupts and are set through a register-write port. The other eleven bits track hardware request levels. These arrive as indexed level updates, one line per cycle.

A per-line enable mask filters the pending field. When any enabled line is pending, the block drives a wake indication and reports the number of the highest enabled pending line, with a valid flag. Delivery to the exception unit also needs the global enable set and debug mode clear. It is signalled by a registered one-cycle request each time the delivery condition becomes true. Exception entry is done elsewhere.

Top module: `irq_gate`

## Requirements
- R1: A line update with index 2 to 12 sets that line's pending bit when `line_level` is 1 and clears it when it is 0. The new value shows on the outputs after the next rising clock edge.
- R2: A line update whose index is 0, 1 or 13 to 15 changes no state.
- R3: A register write with `cfg_sel` = 1 loads `cfg_wdata[1:0]` into pending bits 1:0. A register write with `cfg_sel` = 0 loads all 13 bits of `cfg_wdata` into the enable mask.
- R4: An interrupt counts as pending only when the bitwise AND of the pending field and the enable mask is nonzero.
- R5: `take_irq` is never raised unless, in the previous cycle, `glb_en` was 1 and `dbg_mode` was 0.
- R6: `wake` is 1 exactly when the masked pending field is nonzero, whatever the values of `glb_en` and `dbg_mode`.
- R7: `vec` gives the index of the most significant set bit of the masked pending field.
- R8: When the masked pending field is zero, `vec_valid` is 0 and `vec` is 0.
- R9: `take_irq` goes high for exactly one cycle. It rises on the clock edge after the delivery condition (`glb_en`, no debug mode, `wake`) becomes true, and it stays low while that condition holds.
- R10: Reset clears every pending bit, including the two software bits, and zeroes the enable mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_we | input | 1 | Line level update strobe |
| line_idx | input | 4 | Index of the updated line |
| line_level | input | 1 | New level of the indexed line |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Write target: 0 = enable mask, 1 = software pending bits |
| cfg_wdata | input | 13 | Write data |
| glb_en | input | 1 | Global interrupt enable |
| dbg_mode | input | 1 | Core is in debug mode |
| take_irq | output | 1 | One-cycle request to take an interrupt |
| wake | output | 1 | Enabled interrupt is pending |
| vec_valid | output | 1 | `vec` holds a real line number |
| vec | output | 4 | Highest enabled pending line |

## Verification
The first sweep holds all thirteen lines pending and steps the enable mask through all 8192 values. This shows that the reported vector follows the mask's top bit and that masking is a true AND. The second sweep holds the mask at all ones and walks the pending field through every value in Gray-code order, one line per step. This exercises both update paths and every priority pattern. Directed sequences then hold a pending line while combining the global enable and debug mode, which separates wake from delivery and checks that each onset gives a single pulse. Other sequences send out-of-range and software-range indexes to the line port, and reset from a loaded state.

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int NLINES = 13,
  parameter int NSW    = 2,
  localparam int IDXW  = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_we,
  input  logic [IDXW-1:0]   line_idx,
  input  logic              line_level,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [NLINES-1:0] cfg_wdata,
  input  logic              glb_en,
  input  logic              dbg_mode,
  output logic              take_irq,
  output logic              wake,
  output logic              vec_valid,
  output logic [IDXW-1:0]   vec
);

  logic [NLINES-1:0] pend, mask, hit;
  logic deliver, deliver_q;

  for (genvar g = 0; g < NLINES; g++) begin : g_pend
    if (g < NSW) begin : g_sw
      always_ff @(posedge clk)
        if (!rst_n) pend[g] <= 1'b0;
        else if (cfg_we && cfg_sel) pend[g] <= cfg_wdata[g];
    end else begin : g_hw
      always_ff @(posedge clk)
        if (!rst_n) pend[g] <= 1'b0;
        else if (line_we && line_idx == IDXW'(g)) pend[g] <= line_level;
    end
  end

  always_ff @(posedge clk)
    if (!rst_n) mask <= '0;
    else if (cfg_we && !cfg_sel) mask <= cfg_wdata;

  assign hit       = pend & mask;
  assign wake      = |hit;
  assign vec_valid = wake;

  always_comb begin
    vec = '0;
    for (int i = 0; i < NLINES; i++)
      if (hit[i]) vec = IDXW'(i);
  end

  assign deliver = glb_en && !dbg_mode && wake;

  always_ff @(posedge clk)
    if (!rst_n) begin
      deliver_q <= 1'b0;
      take_irq  <= 1'b0;
    end else begin
      deliver_q <= deliver;
      take_irq  <= deliver && !deliver_q;
    end

endmodule

module irq_gate_chk #(
  parameter int NLINES = 13,
  localparam int IDXW  = $clog2(NLINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_we,
  input logic [IDXW-1:0]   line_idx,
  input logic              line_level,
  input logic              cfg_we,
  input logic              cfg_sel,
  input logic [NLINES-1:0] cfg_wdata,
  input logic              glb_en,
  input logic              dbg_mode,
  input logic              take_irq,
  input logic              wake,
  input logic              vec_valid,
  input logic [IDXW-1:0]   vec
);

  // R9
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> !take_irq);

  // R5
  take_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(glb_en && !dbg_mode));

  // R2
  bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_we && (line_idx < 2 || int'(line_idx) >= NLINES) && !cfg_we)
      |=> ($stable(wake) && $stable(vec) && $stable(vec_valid)));

  // R8
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> vec == '0);

  // R4
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel && cfg_wdata == '0) |=> !wake);

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!wake && !take_irq));

endmodule

bind irq_gate irq_gate_chk #(.NLINES(NLINES)) u_irq_gate_chk (.*);

// File: tb/test_irq_gate.sv
`timescale 1ns/1ps
module test_irq_gate;
  localparam int N = 13;

  logic clk = 0, rst_n = 0;
  logic line_we = 0, line_level = 0, cfg_we = 0, cfg_sel = 0;
  logic [3:0] line_idx = 0;
  logic [N-1:0] cfg_wdata = 0;
  logic glb_en = 0, dbg_mode = 0;
  logic take_irq, wake, vec_valid;
  logic [3:0] vec;

  int checks = 0, errors = 0;
  logic [N-1:0] m_pend = 0, m_mask = 0;

  always #2 clk = ~clk;

  irq_gate i_irq_gate (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_line(input int idx, input bit lvl);
    @(negedge clk);
    line_we = 1; line_idx = 4'(idx); line_level = lvl;
    @(negedge clk);
    line_we = 0;
    if (idx >= 2 && idx < N) m_pend[idx] = lvl;
  endtask

  task automatic wr_cfg(input bit sel, input logic [N-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (sel) m_pend[1:0] = d[1:0]; else m_mask = d;
  endtask

  task automatic chk_out(input string req);
    logic [N-1:0] h;
    int ev;
    h = m_pend & m_mask;
    ev = 0;
    for (int i = 0; i < N; i++) if (h[i]) ev = i;
    chk(wake == (h != 0), {req, " wake"}, int'(wake), int'(h != 0));
    chk(vec_valid == (h != 0), {req, " vec_valid"}, int'(vec_valid), int'(h != 0));
    chk(int'(vec) == ev, {req, " vec"}, int'(vec), ev);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    m_pend = 0; m_mask = 0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R10 reset state
    chk(!wake && !vec_valid && !take_irq, "R10 reset outputs", int'(wake), 0);

    // R1 R3: load all lines pending
    wr_cfg(1, N'(3));
    for (int i = 2; i < N; i++) wr_line(i, 1);
    // R4 R7 R8 mask sweep
    for (int m = 0; m < (1 << N); m++) begin
      wr_cfg(0, N'(m));
      chk_out("R4 R7 R8 mask sweep");
    end

    // R1 R3 R7 Gray-code pending walk with full mask
    wr_cfg(0, '1);
    wr_cfg(1, '0);
    for (int i = 2; i < N; i++) wr_line(i, 0);
    chk_out("R8 all clear");
    for (int i = 1; i < (1 << N); i++) begin
      int b;
      logic [N-1:0] gc;
      gc = N'(i ^ (i >> 1));
      b = 0;
      while (((i >> b) & 1) == 0) b++;
      if (b < 2) wr_cfg(1, gc);
      else wr_line(b, gc[b]);
      chk_out("R1 R3 R7 pending walk");
    end

    // R10 reset from loaded state
    do_reset();
    chk(!wake && !vec_valid && !take_irq, "R10 after load", int'(wake), 0);
    wr_line(3, 1);
    chk(!wake, "R10 mask zeroed", int'(wake), 0);
    wr_cfg(0, '1);
    chk(int'(vec) == 3 && wake, "R10 sw bits cleared", int'(vec), 3);
    wr_line(3, 0);

    // R2 ignored indexes
    for (int k = 0; k < 5; k++) begin
      int idx;
      idx = (k < 2) ? k : 11 + k;
      wr_line(idx, 1);
      chk(!wake && !vec_valid, "R2 ignored index", int'(wake), 0);
    end
    wr_cfg(1, N'(2));
    chk(int'(vec) == 1 && wake, "R3 sw bit 1", int'(vec), 1);
    wr_line(1, 0);
    chk(int'(vec) == 1 && wake, "R2 index 1 ignored", int'(vec), 1);
    wr_cfg(1, '0);

    // R5 R6 R9 gating
    wr_cfg(0, N'(1 << 5));
    wr_line(5, 1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!take_irq, "R5 global disabled", int'(take_irq), 0);
      chk(wake, "R6 wake without enable", int'(wake), 1);
    end
    dbg_mode = 1; glb_en = 1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!take_irq, "R5 debug blocks", int'(take_irq), 0);
      chk(wake, "R6 wake in debug", int'(wake), 1);
    end
    dbg_mode = 0;
    @(negedge clk);
    chk(take_irq, "R9 pulse high", int'(take_irq), 1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!take_irq, "R9 pulse single", int'(take_irq), 0);
    end
    wr_line(5, 0);
    wr_line(5, 1);
    chk(!take_irq, "R9 before second", int'(take_irq), 0);
    @(negedge clk);
    chk(take_irq, "R9 second onset", int'(take_irq), 1);
    @(negedge clk);
    chk(!take_irq, "R9 second single", int'(take_irq), 0);
    glb_en = 0;
    @(negedge clk);
    chk(wake && int'(vec) == 5, "R6 R7 after disable", int'(vec), 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule